// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, while a frame header is still arriving, whether the frame should be kept. The six destination octets are presented one per strobe, first octet first, and the block compares them on the fly against a programmed station address, the all-ones broadcast address and a short table of three-octet multicast prefixes. Two override controls widen the filter. One keeps every frame. The other keeps every frame sent to a group address.

Each comparator keeps a running "still matching" flag that is updated as each octet arrives, so no address is buffered. One cycle after the sixth octet is taken, a one-cycle strobe marks the decision. The accept level then holds until the next frame start clears it. Octets after the sixth are ignored. Configuration inputs are expected to stay stable for the length of a header.

Top module: `rx_addr_filter`

## Requirements
- R1: The station address is the 48-bit value {station_hi[15:0], station_lo[31:0]}, with octet 0 (the first on the wire) in station_hi[15:8] and octet 5 in station_lo[7:0]. A frame whose six destination octets equal it, in order, is accepted; a difference in any octet rejects it unless another rule accepts.
- R2: A destination of FF:FF:FF:FF:FF:FF is always accepted.
- R3: A group destination (bit 0 of octet 0 set) is accepted when its first three octets equal a multicast table entry. Entry i sits at mask_table[24*i+23 : 24*i], packing octet 0 in bits 23:16, octet 1 in bits 15:8 and octet 2 in bits 7:0. All entries are checked, the last one included.
- R4: A table entry of zero never matches, and a table prefix match on a destination with bit 0 of octet 0 clear does not accept it.
- R5: With cfg_promisc high when the sixth octet is taken, the frame is accepted whatever its destination. With it low, that rule does not apply.
- R6: With cfg_all_mcast high, every group destination is accepted, and individual destinations still follow R1 and R2.
- R7: decision_valid is high for exactly one cycle, in the cycle after the edge that takes the sixth destination octet. accept carries the verdict from that same cycle on.
- R8: Octets strobed after the sixth and before the next frame start have no effect. No further decision_valid is raised and accept holds its value.
- R9: A frame_start pulse clears accept and the octet count from the next cycle on. An octet strobed in the same cycle as frame_start counts as octet 0 of the new frame.
- R10: During and right after reset, decision_valid and accept are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle pulse at the start of a new frame header |
| octet_valid | input | 1 | Destination octet strobe |
| octet_data | input | 8 | Destination octet, first octet of the address first |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_all_mcast | input | 1 | Accept every group destination |
| station_hi | input | 16 | Station address octets 0 and 1 |
| station_lo | input | 32 | Station address octets 2 to 5 |
| mask_table | input | 96 | Four 24-bit multicast prefix entries |
| decision_valid | output | 1 | One-cycle strobe marking a fresh decision |
| accept | output | 1 | Verdict of the most recent frame, cleared by frame_start |

## Verification
The verdict is due exactly one clock edge after the sixth octet is taken, so the bench drives each octet on a falling edge and reads decision_valid and accept on the falling edge after the next rising edge. It then reads again one cycle later to confirm that the strobe has dropped. The clearing effect of frame_start also shows one edge after the pulse, and the bench samples there. For ignored trailing octets, the bench watches several cycles after each extra strobe to confirm that both outputs stay unchanged.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int OCTET_W       = 8;
  localparam int ADDR_OCTETS   = 6;
  localparam int PREFIX_OCTETS = 3;
  localparam int PREFIX_W      = PREFIX_OCTETS * OCTET_W;
  localparam int ADDR_W        = ADDR_OCTETS * OCTET_W;
  localparam int POS_W         = $clog2(ADDR_OCTETS + 1);

  typedef logic [OCTET_W-1:0] octet_t;
  typedef logic [POS_W-1:0]   pos_t;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/rx_octet_seq.sv
module rx_octet_seq
  import rx_filt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic octet_valid,
  output logic take,
  output logic last,
  output pos_t pos
);
  pos_t cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    pos    = frame_start ? '0 : cnt_q;
    take   = octet_valid && (pos < pos_t'(ADDR_OCTETS));
    last   = take && (pos == pos_t'(ADDR_OCTETS - 1));
    cnt_en = frame_start || take;
    cnt_d  = take ? pos + pos_t'(1) : pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= pos_t'(ADDR_OCTETS);
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rx_prefix_cmp.sv
module rx_prefix_cmp
  import rx_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                take,
  input  pos_t                pos,
  input  octet_t              octet,
  input  logic [PREFIX_W-1:0] entry,
  output logic                hit
);
  logic   run_q, run_d, base;
  octet_t want;
  logic   in_prefix;

  always_comb begin
    want      = '0;
    in_prefix = 1'b0;
    for (int k = 0; k < PREFIX_OCTETS; k++) begin
      if (pos == pos_t'(k)) begin
        want      = entry[(PREFIX_OCTETS-1-k)*OCTET_W +: OCTET_W];
        in_prefix = 1'b1;
      end
    end
    base  = frame_start ? 1'b1 : run_q;
    run_d = (take && in_prefix) ? (base && (octet == want)) : base;
    hit   = run_d && (entry != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_q <= 1'b0;
    else if (frame_start || take)  run_q <= run_d;
  end
endmodule

// File: rtl/rx_addr_cmp.sv
module rx_addr_cmp
  import rx_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              take,
  input  pos_t              pos,
  input  octet_t            octet,
  input  logic [ADDR_W-1:0] station,
  output logic              st_hit,
  output logic              bc_hit,
  output logic              grp_hit
);
  logic   st_q, bc_q, grp_q;
  logic   st_base, bc_base, grp_base;
  octet_t want;
  logic   upd;

  always_comb begin
    want = '0;
    for (int k = 0; k < ADDR_OCTETS; k++) begin
      if (pos == pos_t'(k)) want = station[(ADDR_OCTETS-1-k)*OCTET_W +: OCTET_W];
    end
    st_base  = frame_start ? 1'b1 : st_q;
    bc_base  = frame_start ? 1'b1 : bc_q;
    grp_base = frame_start ? 1'b0 : grp_q;
    st_hit   = take ? (st_base && (octet == want)) : st_base;
    bc_hit   = take ? (bc_base && (&octet)) : bc_base;
    grp_hit  = (take && (pos == '0)) ? octet[0] : grp_base;
    upd      = frame_start || take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      bc_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (upd) begin
      st_q  <= st_hit;
      bc_q  <= bc_hit;
      grp_q <= grp_hit;
    end
  end
endmodule

// File: rtl/rx_filter_decide.sv
module rx_filter_decide #(
  parameter int N_MASKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               last,
  input  logic               promisc,
  input  logic               all_mcast,
  input  logic               st_hit,
  input  logic               bc_hit,
  input  logic               grp_hit,
  input  logic [N_MASKS-1:0] prefix_hit,
  output logic               decision_valid,
  output logic               accept
);
  logic verdict, acc_d, acc_en, vld_d;

  always_comb begin
    verdict = promisc || st_hit || bc_hit || (grp_hit && (all_mcast || (|prefix_hit)));
    acc_en  = frame_start || last;
    acc_d   = last && verdict;
    vld_d   = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept         <= 1'b0;
      decision_valid <= 1'b0;
    end else begin
      decision_valid <= vld_d;
      if (acc_en) accept <= acc_d;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int N_MASKS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic                        octet_valid,
  input  logic [7:0]                  octet_data,
  input  logic                        cfg_promisc,
  input  logic                        cfg_all_mcast,
  input  logic [15:0]                 station_hi,
  input  logic [31:0]                 station_lo,
  input  logic [N_MASKS*PREFIX_W-1:0] mask_table,
  output logic                        decision_valid,
  output logic                        accept
);
  logic              rst_core_n;
  logic              take, last;
  pos_t              pos;
  logic              st_hit, bc_hit, grp_hit;
  logic [N_MASKS-1:0] prefix_hit;
  logic [ADDR_W-1:0] station;

  assign station = {station_hi, station_lo};

  rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  rx_octet_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .frame_start(frame_start),
    .octet_valid(octet_valid), .take(take), .last(last), .pos(pos)
  );

  rx_addr_cmp u_addr (
    .clk(clk), .rst_n(rst_core_n), .frame_start(frame_start), .take(take),
    .pos(pos), .octet(octet_data), .station(station),
    .st_hit(st_hit), .bc_hit(bc_hit), .grp_hit(grp_hit)
  );

  for (genvar i = 0; i < N_MASKS; i++) begin : g_prefix
    rx_prefix_cmp u_pfx (
      .clk(clk), .rst_n(rst_core_n), .frame_start(frame_start), .take(take),
      .pos(pos), .octet(octet_data),
      .entry(mask_table[i*PREFIX_W +: PREFIX_W]), .hit(prefix_hit[i])
    );
  end

  rx_filter_decide #(.N_MASKS(N_MASKS)) u_dec (
    .clk(clk), .rst_n(rst_core_n), .frame_start(frame_start), .last(last),
    .promisc(cfg_promisc), .all_mcast(cfg_all_mcast),
    .st_hit(st_hit), .bc_hit(bc_hit), .grp_hit(grp_hit),
    .prefix_hit(prefix_hit), .decision_valid(decision_valid), .accept(accept)
  );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic octet_valid,
  input logic cfg_promisc,
  input logic decision_valid,
  input logic accept
);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);

  p_valid_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> ($past(octet_valid) && !$past(frame_start)));

  p_promisc_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && $past(cfg_promisc)) |-> accept);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!accept && !decision_valid));

  p_accept_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(accept) |-> (decision_valid || $past(frame_start)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!decision_valid && !accept));
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .octet_valid(octet_valid), .cfg_promisc(cfg_promisc),
  .decision_valid(decision_valid), .accept(accept)
);

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        octet_valid = 1'b0;
  logic [7:0]  octet_data = '0;
  logic        cfg_promisc = 1'b0;
  logic        cfg_all_mcast = 1'b0;
  logic [15:0] station_hi = 16'h0211;
  logic [31:0] station_lo = 32'h2233_4455;
  logic [95:0] mask_table = {24'h0180C2, 24'h000000, 24'h021122, 24'h01005E};
  logic        decision_valid, accept;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .octet_valid(octet_valid),
    .octet_data(octet_data), .cfg_promisc(cfg_promisc), .cfg_all_mcast(cfg_all_mcast),
    .station_hi(station_hi), .station_lo(station_lo), .mask_table(mask_table),
    .decision_valid(decision_valid), .accept(accept)
  );

  // {destination, promisc, all_mcast, expected accept}
  localparam int NV = 13;
  localparam logic [50:0] VECS [NV] = '{
    {48'h0211_2233_4455, 1'b0, 1'b0, 1'b1},  // R1 exact station
    {48'h0211_2233_4456, 1'b0, 1'b0, 1'b0},  // R1 last octet differs
    {48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1},  // R2 broadcast
    {48'h0100_5E01_0203, 1'b0, 1'b0, 1'b1},  // R3 entry 0
    {48'h0180_C200_000E, 1'b0, 1'b0, 1'b1},  // R3 entry 3
    {48'h0100_5F00_0001, 1'b0, 1'b0, 1'b0},  // R3 prefix miss
    {48'h0211_2299_9999, 1'b0, 1'b0, 1'b0},  // R4 prefix on individual addr
    {48'h0000_0000_0000, 1'b0, 1'b0, 1'b0},  // R4 zero entry
    {48'h0A0B_0C0D_0E0F, 1'b1, 1'b0, 1'b1},  // R5 promisc on
    {48'h0300_0000_0001, 1'b0, 1'b1, 1'b1},  // R6 group, all-mcast
    {48'h0A0B_0C0D_0E0F, 1'b0, 1'b1, 1'b0},  // R6 individual, all-mcast
    {48'hFFFF_FFFF_FFFE, 1'b0, 1'b0, 1'b0},  // R3 group without prefix
    {48'h0A0B_0C0D_0E0F, 1'b0, 1'b0, 1'b0}   // R5 promisc off
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:         return "R1";
      2:            return "R2";
      3, 4, 5, 11:  return "R3";
      6, 7:         return "R4";
      8, 12:        return "R5";
      default:      return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      frame_start = 1'b0;
      octet_valid = 1'b0;
    end
  endtask

  task automatic put_octet(input logic [7:0] o, input logic fs);
    @(negedge clk);
    frame_start = fs;
    octet_valid = 1'b1;
    octet_data  = o;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    frame_start = 1'b1;
    octet_valid = 1'b0;
  endtask

  task automatic send_addr(input logic [47:0] a, input int gap);
    for (int k = 0; k < 6; k++) begin
      put_octet(a[47-8*k -: 8], 1'b0);
      if (gap > 0 && k < 5) idle(gap);
    end
  endtask

  // Verdict is due one edge after the sixth octet; strobe gone one edge later.
  task automatic expect_decision(input logic exp, input string tag);
    idle(1);
    check(tag, {31'b0, decision_valid}, 32'd1);
    check(tag, {31'b0, accept}, {31'b0, exp});
    idle(1);
    check(tag, {31'b0, decision_valid}, 32'd0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < 50000 cycles", cycles);
        finish_up();
      end
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", {30'b0, decision_valid, accept}, 32'd0);
    rst_n = 1'b1;
    idle(5);
    check("R10", {30'b0, decision_valid, accept}, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      cfg_promisc   = VECS[i][2];
      cfg_all_mcast = VECS[i][1];
      pulse_start();
      send_addr(VECS[i][50:3], 0);
      expect_decision(VECS[i][0], vec_tag(i));
    end
    cfg_promisc   = 1'b0;
    cfg_all_mcast = 1'b0;

    // R7: no strobe before sixth octet; gaps between octets allowed
    pulse_start();
    for (int k = 0; k < 5; k++) begin
      put_octet(8'hFF, 1'b0);
      idle(2);
    end
    check("R7", {31'b0, decision_valid}, 32'd0);
    put_octet(8'hFF, 1'b0);
    expect_decision(1'b1, "R7");

    // R8: trailing octets ignored, accept held
    for (int k = 0; k < 3; k++) begin
      put_octet(8'h00, 1'b0);
      idle(2);
      check("R8", {30'b0, decision_valid, accept}, 32'd1);
    end

    // R9: frame_start clears accept
    pulse_start();
    idle(1);
    check("R9", {30'b0, decision_valid, accept}, 32'd0);

    // R9: restart mid-header with frame_start on the first octet
    send_addr(48'h0A0B_0C0D_0E0F, 0);
    pulse_start();
    put_octet(8'h0A, 1'b0);
    put_octet(8'h0B, 1'b0);
    put_octet(8'h02, 1'b1);
    put_octet(8'h11, 1'b0);
    put_octet(8'h22, 1'b0);
    put_octet(8'h33, 1'b0);
    put_octet(8'h44, 1'b0);
    put_octet(8'h55, 1'b0);
    expect_decision(1'b1, "R9");

    // R1: station reprogrammed, old address now rejected
    station_hi = 16'hA0B1;
    station_lo = 32'hC2D3_E4F6;
    pulse_start();
    send_addr(48'h0211_2233_4455, 1);
    expect_decision(1'b0, "R1");
    pulse_start();
    send_addr(48'hA0B1_C2D3_E4F6, 1);
    expect_decision(1'b1, "R1");

    // R10: reset mid-frame clears state
    pulse_start();
    put_octet(8'hFF, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    octet_valid = 1'b0;
    @(negedge clk);
    check("R10", {30'b0, decision_valid, accept}, 32'd0);
    rst_n = 1'b1;
    idle(4);
    check("R10", {30'b0, decision_valid, accept}, 32'd0);

    finish_up();
  end
endmodule